// File: doc/BRIEF.md
# Serial Byte XOR-Rotate Cipher

This block scrambles a bit-serial link with a fixed key. Qualified serial bits are packed into a byte, most significant bit first. Each full byte is XORed with an 8-bit key and then rotated by a fixed number of bit positions. The result is placed in a holding register and sent out again as a serial stream, most significant bit first. A parameter selects the encrypt or the decrypt variant. The decrypt variant rotates the key before use and rotates the data the other way, so it undoes the encrypt variant exactly.

A typical link puts an encrypting instance at the sending end and a decrypting instance at the receiving end, both wired to the same static key. The bit stream then arrives unchanged. If the two keys differ, the bytes that arrive are corrupted. All internal timing (bit capture, byte transfer and bit emission) runs from one clock, with internal strobes.

Top module: `nibswap_cipher`

## Requirements
- R1: A bit on `ser_in` is taken only in a cycle where `ser_in_vld` is 1. The first bit taken becomes bit 7 of the byte (MSB first). Cycles where `ser_in_vld` is 0 have no effect, whatever `ser_in` holds.
- R2: The eighth bit taken completes a byte and moves it into the holding register in that same clock edge. The bit count then starts again from zero, so every 8 taken bits produce exactly one output byte.
- R3: In encrypt mode (MODE = MODE_ENC) the output byte is rotl(d XOR key, ROT), where rotl is a left rotation. With the default ROT = 4 this swaps the two nibbles.
- R4: In decrypt mode (MODE = MODE_DEC) the key is first rotated left by ROT, XORed with the byte, and the result is rotated left by 8-ROT. The output is therefore rotr(d, ROT) XOR key.
- R5: Timing of a byte. Let E be the clock edge that samples the eighth bit. After edge E+1, `ser_out_vld` is 1 for exactly 8 cycles. `ser_out` carries the byte's bit 7 first and bit 0 last. `ser_out` is 0 whenever `ser_out_vld` is 0.
- R6: If input bytes arrive back to back (eight valid bits per 8 cycles), the output stays valid with no gap for 8 cycles per byte.
- R7: An encryptor feeding a decryptor with the same key returns every plaintext byte unchanged. If the keys differ, every byte comes back altered.
- R8: A synchronous active-low reset clears the bit count, all data registers and `ser_out_vld`. A partly collected byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bit capture, byte transfer and bit emission |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_in | input | 1 | Serial data in, MSB first |
| ser_in_vld | input | 1 | Qualifies `ser_in` in the current cycle |
| key | input | 8 | Static key, applied in parallel |
| ser_out | output | 1 | Serial data out, MSB first |
| ser_out_vld | output | 1 | High while a transformed byte is being shifted out |

## Verification
The bench sweeps all 256 byte values back to back through an encryptor, then through a matched decryptor and a mismatched one. This catches a wrong rotation direction or a missing key pre-rotation, since either breaks the round trip or the expected ciphertext. Output continuity over that stream is measured: an emitter that reloads one cycle late, or drops a byte while its predecessor is still shifting, shortens the longest valid run below 8 cycles per byte. Input with idle cycles that carry the inverted data value shows whether a design samples bits without qualification. A single isolated byte pins down the exact cycle of the first output bit and its bit order. A reset in the middle of a byte shows whether stale partial bits leak into the next byte.

// File: rtl/cipher_pkg.sv
// Shared definitions for the serial XOR-rotate cipher.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package cipher_pkg;

    // Selects the direction of the transform applied to each byte.
    typedef enum logic {
        MODE_ENC = 1'b0,
        MODE_DEC = 1'b1
    } cipher_mode_e;

endpackage

// File: rtl/bit_gather.sv
// Serial-to-parallel collector.
// Shifts qualified input bits in MSB first and counts them. On the edge
// that takes the last bit of a word it presents the completed word and a
// one-cycle transfer strobe.
// Assumes: W is at least 2.
module bit_gather #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    input  logic         bit_vld,
    output logic [W-1:0] word_o,
    output logic         word_stb
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [W-2:0]  shreg_q;
    logic [CW-1:0] cnt_q;
    logic          last_bit;

    assign last_bit = (cnt_q == CW'(W - 1));
    assign word_stb = bit_vld && last_bit;
    assign word_o   = {shreg_q, bit_in};

    // Shift in each qualified bit and advance the bit count, wrapping at W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (bit_vld) begin
            shreg_q <= {shreg_q[W-3:0], bit_in};
            cnt_q   <= last_bit ? '0 : cnt_q + CW'(1);
        end
    end

    // R1: an unqualified cycle leaves the collector untouched
    a_r1_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> ($stable(cnt_q) && $stable(shreg_q)));

    // R2: after a completed word the count starts again from zero
    a_r2_count_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> (cnt_q == '0));

    // R8: reset clears the count
    a_r8_gather_reset: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0 && shreg_q == '0));

endmodule

// File: rtl/byte_mixer.sv
// Combinational byte transform: XOR with an effective key, then rotate left.
// Encrypt: effective key = key, rotation = ROT.
// Decrypt: effective key = key rotated left by ROT, rotation = W-ROT,
// which inverts the encrypt transform.
// Assumes: 0 < ROT < W.
module byte_mixer
    import cipher_pkg::*;
#(
    parameter int           W    = 8,
    parameter int           ROT  = 4,
    parameter cipher_mode_e MODE = MODE_ENC
) (
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] key_i,
    output logic [W-1:0] data_o
);
    localparam int ROT_DEC = W - ROT;

    // Rotate x left by n positions (0 <= n < W).
    function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int n);
        logic [2*W-1:0] dbl;
        dbl = {x, x};
        return dbl[2*W-1-n -: W];
    endfunction

    logic [W-1:0] key_eff;
    logic [W-1:0] mixed;

    generate
        if (MODE == MODE_DEC) begin : g_dec
            // Decrypt: pre-rotate the key and rotate the data back.
            always_comb begin
                key_eff = rotl(key_i, ROT);
                mixed   = data_i ^ key_eff;
                data_o  = rotl(mixed, ROT_DEC);
            end
        end else begin : g_enc
            // Encrypt: plain key, forward rotation.
            always_comb begin
                key_eff = key_i;
                mixed   = data_i ^ key_eff;
                data_o  = rotl(mixed, ROT);
            end
        end
    endgenerate

endmodule

// File: rtl/bit_emitter.sv
// Holding register plus parallel-to-serial shifter.
// A word strobe loads the holding register. On the next edge the shifter
// loads it and then sends W bits MSB first, one per cycle, with valid high.
// Assumes: strobes arrive no more often than once every W cycles.
module bit_emitter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_stb,
    input  logic [W-1:0] word_i,
    output logic         bit_out,
    output logic         bit_vld
);
    localparam int LW = $clog2(W + 1);

    logic [W-1:0]  hold_q;
    logic          xfer_q;
    logic [W-1:0]  piso_q;
    logic [LW-1:0] left_q;

    // Capture the transformed word into the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            xfer_q <= 1'b0;
        end else begin
            xfer_q <= load_stb;
            if (load_stb) begin
                hold_q <= word_i;
            end
        end
    end

    // Load the shifter from the holding register, else shift one bit out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            piso_q <= '0;
            left_q <= '0;
        end else if (xfer_q) begin
            piso_q <= hold_q;
            left_q <= LW'(W);
        end else if (left_q != '0) begin
            piso_q <= {piso_q[W-2:0], 1'b0};
            left_q <= left_q - LW'(1);
        end
    end

    assign bit_vld = (left_q != '0);
    assign bit_out = piso_q[W-1] & bit_vld;

    // R5: the first bit after a transfer is the held word's MSB
    a_r5_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_q |=> (bit_out == $past(hold_q[W-1]) && bit_vld));

    // R5: output valid only ever starts right after a transfer
    a_r5_valid_from_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_vld) |-> $past(xfer_q));

    // R6: a new word never cuts the previous one short
    a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_q |-> (left_q <= LW'(1)));

    // R8: reset clears output valid
    a_r8_emit_reset: assert property (@(posedge clk)
        !rst_n |=> !bit_vld);

endmodule

// File: rtl/nibswap_cipher.sv
// Serial XOR-rotate cipher, top level.
// Collects qualified serial bits into a byte, transforms it with the key
// (encrypt or decrypt, chosen by MODE), holds it and shifts it out MSB first.
// Assumes: key is static during operation; a single clock drives all stages.
module nibswap_cipher
    import cipher_pkg::*;
#(
    parameter int           W    = 8,
    parameter int           ROT  = 4,
    parameter cipher_mode_e MODE = MODE_ENC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    input  logic         ser_in_vld,
    input  logic [W-1:0] key,
    output logic         ser_out,
    output logic         ser_out_vld
);
    logic [W-1:0] gathered;
    logic         gather_stb;
    logic [W-1:0] mixed;

    bit_gather #(.W(W)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (ser_in),
        .bit_vld  (ser_in_vld),
        .word_o   (gathered),
        .word_stb (gather_stb)
    );

    byte_mixer #(.W(W), .ROT(ROT), .MODE(MODE)) u_mixer (
        .data_i (gathered),
        .key_i  (key),
        .data_o (mixed)
    );

    bit_emitter #(.W(W)) u_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_stb (gather_stb),
        .word_i   (mixed),
        .bit_out  (ser_out),
        .bit_vld  (ser_out_vld)
    );

    // Independent left rotation used only by the inverse check below.
    function automatic logic [W-1:0] chk_rotl(input logic [W-1:0] x, input int n);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            r[(i + n) % W] = x[i];
        end
        return r;
    endfunction

    generate
        if (MODE == MODE_DEC) begin : g_chk_dec
            // R4: undoing the decrypt transform gives back the gathered byte
            a_r4_inverse: assert property (@(posedge clk) disable iff (!rst_n)
                gather_stb |-> (chk_rotl(mixed ^ key, ROT) == gathered));
        end else begin : g_chk_enc
            // R3: undoing the encrypt transform gives back the gathered byte
            a_r3_inverse: assert property (@(posedge clk) disable iff (!rst_n)
                gather_stb |-> ((chk_rotl(mixed, W - ROT) ^ key) == gathered));
        end
    endgenerate

endmodule

// File: tb/nibswap_cipher_bench.sv
// Bench: encryptor feeding a matched decryptor and a mismatched decryptor.
module nibswap_cipher_bench;
    import cipher_pkg::*;

    localparam logic [7:0] K1 = 8'h6D;
    localparam logic [7:0] K2 = 8'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic din_vld = 1'b0;
    logic enc_do, enc_dv, dec_do, dec_dv, bad_do, bad_dv;

    always #2 clk = ~clk;   // 250 MHz

    nibswap_cipher #(.MODE(MODE_ENC)) u_nibswap_cipher (
        .clk(clk), .rst_n(rst_n), .ser_in(din), .ser_in_vld(din_vld),
        .key(K1), .ser_out(enc_do), .ser_out_vld(enc_dv));

    nibswap_cipher #(.MODE(MODE_DEC)) u_dec_ok (
        .clk(clk), .rst_n(rst_n), .ser_in(enc_do), .ser_in_vld(enc_dv),
        .key(K1), .ser_out(dec_do), .ser_out_vld(dec_dv));

    nibswap_cipher #(.MODE(MODE_DEC)) u_dec_bad (
        .clk(clk), .rst_n(rst_n), .ser_in(enc_do), .ser_in_vld(enc_dv),
        .key(K2), .ser_out(bad_do), .ser_out_vld(bad_dv));

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] enc_b [0:1023];
    logic [7:0] dec_b [0:1023];
    logic [7:0] bad_b [0:1023];
    int enc_n = 0, dec_n = 0, bad_n = 0;
    logic [7:0] ea, da, ba;
    int ec = 0, dc = 0, bc = 0;
    int run = 0, max_run = 0;

    function automatic logic [7:0] rl8(input logic [7:0] x, input int n);
        return (x << n) | (x >> (8 - n));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Collect output bytes from all three instances, away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            ec = 0; dc = 0; bc = 0; run = 0;
        end else begin
            if (enc_dv) begin
                ea = {ea[6:0], enc_do}; ec++;
                if (ec == 8) begin enc_b[enc_n] = ea; enc_n++; ec = 0; end
                run++;
                if (run > max_run) max_run = run;
            end else begin
                run = 0;
            end
            if (dec_dv) begin
                da = {da[6:0], dec_do}; dc++;
                if (dc == 8) begin dec_b[dec_n] = da; dec_n++; dc = 0; end
            end
            if (bad_dv) begin
                ba = {ba[6:0], bad_do}; bc++;
                if (bc == 8) begin bad_b[bad_n] = ba; bad_n++; bc = 0; end
            end
        end
    end

    task automatic send_byte(input logic [7:0] b, input int gap);
        for (int i = 7; i >= 0; i--) begin
            din = b[i];
            din_vld = 1'b1;
            @(negedge clk);
            for (int g = 0; g < gap; g++) begin
                din = ~b[i];
                din_vld = 1'b0;
                @(negedge clk);
            end
        end
        din_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        din_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        logic [7:0] p, c, got;

        // R8: reset state
        repeat (3) @(negedge clk);
        chk(enc_dv == 1'b0 && enc_do == 1'b0, "R8 reset valid", int'({enc_dv, enc_do}), 0);
        rst_n = 1'b1;
        idle(4);
        chk(enc_dv == 1'b0, "R8 idle after reset", int'(enc_dv), 0);

        // R3 R4 R6 R7: all byte values back to back
        base = enc_n;
        max_run = 0;
        for (int v = 0; v < 256; v++) send_byte(8'(v), 0);
        idle(40);
        chk(enc_n - base == 256, "R2 byte count", enc_n - base, 256);
        chk(max_run == 2048, "R6 continuous output", max_run, 2048);
        for (int v = 0; v < 256; v++) begin
            p = 8'(v);
            c = rl8(p ^ K1, 4);
            chk(enc_b[base + v] == c, "R3 ciphertext", int'(enc_b[base + v]), int'(c));
            chk(dec_b[base + v] == p, "R7 round trip", int'(dec_b[base + v]), int'(p));
            chk(bad_b[base + v] == (p ^ K1 ^ K2), "R4 decrypt formula",
                int'(bad_b[base + v]), int'(p ^ K1 ^ K2));
            chk(bad_b[base + v] != p, "R7 wrong key corrupts", int'(bad_b[base + v]), int'(p));
        end

        // R5: exact timing and bit order of one isolated byte
        p = 8'hA5;
        c = rl8(p ^ K1, 4);
        send_byte(p, 0);
        chk(enc_dv == 1'b0, "R5 not yet valid", int'(enc_dv), 0);
        for (int k = 7; k >= 0; k--) begin
            @(negedge clk);
            chk(enc_dv == 1'b1 && enc_do == c[k], "R5 bit order",
                int'({enc_dv, enc_do}), int'({1'b1, c[k]}));
        end
        @(negedge clk);
        chk(enc_dv == 1'b0 && enc_do == 1'b0, "R5 valid ends", int'({enc_dv, enc_do}), 0);
        idle(30);

        // R1 R2: gapped input with inverted data in the idle cycles
        base = enc_n;
        for (int i = 0; i < 16; i++) send_byte(8'(i * 37 + 11), (i % 3) + 1);
        idle(40);
        chk(enc_n - base == 16, "R2 gapped byte count", enc_n - base, 16);
        for (int i = 0; i < 16; i++) begin
            p = 8'(i * 37 + 11);
            chk(enc_b[base + i] == rl8(p ^ K1, 4), "R1 gapped ciphertext",
                int'(enc_b[base + i]), int'(rl8(p ^ K1, 4)));
            chk(dec_b[base + i] == p, "R1 gapped round trip", int'(dec_b[base + i]), int'(p));
        end

        // R8: reset in the middle of a byte discards the partial bits
        din = 1'b1; din_vld = 1'b1;
        repeat (3) @(negedge clk);
        din_vld = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(enc_dv == 1'b0, "R8 valid cleared", int'(enc_dv), 0);
        rst_n = 1'b1;
        base = enc_n;
        p = 8'h0F;
        send_byte(p, 0);
        idle(40);
        chk(enc_n - base == 1, "R8 one byte after reset", enc_n - base, 1);
        got = enc_b[base];
        chk(got == rl8(p ^ K1, 4), "R8 partial bits dropped", int'(got), int'(rl8(p ^ K1, 4)));
        chk(dec_b[base] == p, "R8 round trip after reset", int'(dec_b[base]), int'(p));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule